// File: doc/BRIEF.md
# Dynamic Bus-Width Sizing Master

This block turns 16-bit read and write requests from a local requester into cycles on a synchronous parallel system bus. The bus has separate memory and I/O address spaces. Memory addresses are 24 bits wide and I/O port numbers are 16 bits wide. The master does not know in advance whether the addressed slave has a full word path. In the address phase of a cycle it raises a word-request line. It then samples the slave's word-acknowledge on the clock edge that ends that phase.

If the slave acknowledges, the whole word moves in one cycle. If the slave stays silent, the master handles the slave as a byte device. It completes the low byte at the request address, then runs a second cycle for the high byte at the next address, and only then reports completion. Requests that enable only one byte always go out as a single byte cycle, and the word request is not raised for them. A slave wait line stretches the data phase of whichever cycle is running.

Requests enter through a valid/ready port. Ready is high only while the master is idle, so the requester holds its request until the master accepts it. Completion is a one-cycle response pulse with no back-pressure. The requester must be able to take the read word in that cycle.

Top module: `dyn_width_master`

## Requirements
- R1: `req_ready` is high exactly when the master is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Request inputs presented while the master is busy have no effect on the bus cycles or on the response.
- R2: The first bus cycle starts one clock after acceptance. Every bus cycle has an address phase of exactly one clock (`bus_sync` high) followed by a data phase. `bus_cyc` is high through both phases, and `bus_wr` gives the request's direction throughout.
- R3: `bus_wide_req` is high during the address phase of the first cycle of a request whose byte enables are `2'b11`. It is low in every other phase, in the second cycle of a split, and for single-byte requests.
- R4: When `bus_wide_ack` is high on the edge that ends an address phase with `bus_wide_req` high, the request completes in that one cycle. `bus_wdata` carries the full word, and the read word is taken whole from `bus_rdata`.
- R5: When that acknowledge is low, the request runs as two byte cycles. The first is at address A and carries the low byte, the second is at A+1 and carries the high byte. In byte cycles the byte travels on `bus_wdata[7:0]`/`bus_rdata[7:0]`, `bus_wdata[15:8]` is zero and `bus_rdata[15:8]` is ignored.
- R6: With `req_be` = `2'b01` a single byte cycle runs at A, and its read byte returns in `rsp_rdata[7:0]`. With `req_be` = `2'b10` it runs at A+1, and its read byte returns in `rsp_rdata[15:8]`. The unused half of `rsp_rdata` is zero.
- R7: `bus_wait` high on a data-phase edge extends that data phase by one clock, and the address and write data hold steady meanwhile.
- R8: `rsp_valid` pulses for exactly one clock, in the cycle after the final data phase ends. `rsp_rdata` is valid with it and is zero for writes. Latency from acceptance is N*(2+W)+1 clocks, for N bus cycles each stretched by W waits.
- R9: With `req_io` high, `bus_io` is high during the cycles and `bus_addr[23:16]` is zero. The A+1 step wraps within 16 bits for I/O and within 24 bits for memory.
- R10: A request with `req_be` = `2'b00` runs no bus cycle. Its response comes one clock after acceptance, with `rsp_rdata` zero.
- R11: After reset the master is idle. `req_ready` is high, and `bus_cyc`, `bus_wide_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request accepted this edge if valid |
| req_addr | input | 24 | Byte address A (upper 8 bits ignored for I/O) |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write word, low byte for A, high byte for A+1 |
| req_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read word returned with the pulse |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_sync | output | 1 | Address phase marker |
| bus_addr | output | 24 | Bus address |
| bus_io | output | 1 | Cycle addresses I/O space |
| bus_wr | output | 1 | Cycle is a write |
| bus_wide_req | output | 1 | Word transfer requested |
| bus_wide_ack | input | 1 | Slave accepts a word transfer |
| bus_wait | input | 1 | Slave stretches the data phase |
| bus_wdata | output | 16 | Write data lanes |
| bus_rdata | input | 16 | Read data lanes |

## Verification
Some properties are checked on every clock. Ready never overlaps a bus cycle, and the word request appears only in an address phase and only for a two-byte request. A stretched data phase holds its address and data, the second cycle of a split steps the address by exactly one with the right wrap, I/O addresses keep their upper bits clear, and the response is a single pulse. Other behaviour can only be shown by the bench's scenarios, which play a slave that does or does not acknowledge and inserts waits. These cover whether the bytes land in the correct halves of the returned word, whether a silent slave really gets two cycles in low-then-high order, the exact completion latency, and whether requests offered while busy leave the bus traffic untouched.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } dwm_state_e;

  // Which byte lanes the current bus cycle moves
  typedef enum logic [1:0] {
    LN_NONE = 2'd0,
    LN_LO   = 2'd1,
    LN_HI   = 2'd2,
    LN_BOTH = 2'd3
  } dwm_lane_e;

  function automatic dwm_lane_e first_lane(input logic [1:0] be);
    case (be)
      2'b11:   first_lane = LN_BOTH;
      2'b01:   first_lane = LN_LO;
      2'b10:   first_lane = LN_HI;
      default: first_lane = LN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dwm_req_reg.sv
module dwm_req_reg #(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MEM_AW-1:0] in_addr,
  input  logic              in_io,
  input  logic              in_wr,
  input  logic [WORD_W-1:0] in_wdata,
  input  logic [1:0]        in_be,
  output logic [MEM_AW-1:0] q_addr,
  output logic              q_io,
  output logic              q_wr,
  output logic [WORD_W-1:0] q_wdata,
  output logic [1:0]        q_be
);

  localparam logic [MEM_AW-1:0] IO_MASK = {{(MEM_AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_io    <= 1'b0;
      q_wr    <= 1'b0;
      q_wdata <= '0;
      q_be    <= '0;
    end else if (load) begin
      q_addr  <= in_io ? (in_addr & IO_MASK) : in_addr;
      q_io    <= in_io;
      q_wr    <= in_wr;
      q_wdata <= in_wdata;
      q_be    <= in_be;
    end
  end

endmodule

// File: rtl/dwm_seq.sv
module dwm_seq
  import dwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_be,
  input  logic       wide_ack,
  input  logic       bus_wait,
  output dwm_state_e state_q,
  output dwm_lane_e  lane_q,
  output logic       accept,
  output logic       capture
);

  logic split_q;

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign capture = (state_q == ST_DATA) && !bus_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= LN_NONE;
      split_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            split_q <= 1'b0;
            lane_q  <= first_lane(req_be);
            state_q <= (req_be == 2'b00) ? ST_FIN : ST_ADDR;
          end
        end
        ST_ADDR: begin
          state_q <= ST_DATA;
          if ((lane_q == LN_BOTH) && !wide_ack) begin
            lane_q  <= LN_LO;
            split_q <= 1'b1;
          end
        end
        ST_DATA: begin
          if (!bus_wait) begin
            if (split_q) begin
              lane_q  <= LN_HI;
              split_q <= 1'b0;
              state_q <= ST_ADDR;
            end else begin
              lane_q  <= LN_NONE;
              state_q <= ST_FIN;
            end
          end
        end
        default: begin
          lane_q  <= LN_NONE;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: a held data phase keeps its lane selection
  a_r7_wait_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && bus_wait) |=> (state_q == ST_DATA && $stable(lane_q)))
    else $error("R7 data phase left while wait high");

  // R5: a refused word turns into a low-byte cycle
  a_r5_refusal_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && lane_q == LN_BOTH && !wide_ack) |=> (lane_q == LN_LO))
    else $error("R5 refused word did not fall back to low byte");

endmodule

// File: rtl/dwm_datapath.sv
module dwm_datapath
  import dwm_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  dwm_lane_e         lane,
  input  logic [MEM_AW-1:0] q_addr,
  input  logic              q_io,
  input  logic              q_wr,
  input  logic [WORD_W-1:0] q_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam logic [MEM_AW-1:0] IO_MASK  = {{(MEM_AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};
  localparam logic [MEM_AW-1:0] MEM_MASK = {MEM_AW{1'b1}};

  logic step;
  assign step     = (lane == LN_HI);
  assign bus_addr = (q_addr + {{(MEM_AW-1){1'b0}}, step}) & (q_io ? IO_MASK : MEM_MASK);

  always_comb begin
    case (lane)
      LN_BOTH: bus_wdata = q_wdata;
      LN_LO:   bus_wdata = {{BYTE_W{1'b0}}, q_wdata[BYTE_W-1:0]};
      LN_HI:   bus_wdata = {{BYTE_W{1'b0}}, q_wdata[WORD_W-1:BYTE_W]};
      default: bus_wdata = '0;
    endcase
  end

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic              take;
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] byte_q;

    assign take = (lane == LN_BOTH) || ((k == 0) ? (lane == LN_LO) : (lane == LN_HI));
    assign src  = (lane == LN_BOTH) ? bus_rdata[k*BYTE_W +: BYTE_W] : bus_rdata[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         byte_q <= '0;
      else if (clear)                     byte_q <= '0;
      else if (capture && take && !q_wr)  byte_q <= src;
    end

    assign rdata[k*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/dyn_width_master.sv
module dyn_width_master
  import dwm_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic              req_io,
  input  logic              req_wr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              bus_cyc,
  output logic              bus_sync,
  output logic [MEM_AW-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_wr,
  output logic              bus_wide_req,
  input  logic              bus_wide_ack,
  input  logic              bus_wait,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata
);

  localparam logic [MEM_AW-1:0] IO_MASK  = {{(MEM_AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};
  localparam logic [MEM_AW-1:0] MEM_MASK = {MEM_AW{1'b1}};
  localparam logic [MEM_AW-1:0] ONE      = {{(MEM_AW-1){1'b0}}, 1'b1};

  dwm_state_e        state;
  dwm_lane_e         lane;
  logic              accept, capture;
  logic [MEM_AW-1:0] q_addr;
  logic              q_io, q_wr;
  logic [WORD_W-1:0] q_wdata;
  logic [1:0]        q_be;

  dwm_req_reg #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .BYTE_W(BYTE_W)) u_req (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_addr(req_addr), .in_io(req_io), .in_wr(req_wr),
    .in_wdata(req_wdata), .in_be(req_be),
    .q_addr(q_addr), .q_io(q_io), .q_wr(q_wr), .q_wdata(q_wdata), .q_be(q_be)
  );

  dwm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be(req_be),
    .wide_ack(bus_wide_ack), .bus_wait(bus_wait),
    .state_q(state), .lane_q(lane), .accept(accept), .capture(capture)
  );

  dwm_datapath #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(capture), .lane(lane),
    .q_addr(q_addr), .q_io(q_io), .q_wr(q_wr), .q_wdata(q_wdata),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rdata(rsp_rdata)
  );

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_FIN);
  assign bus_sync     = (state == ST_ADDR);
  assign bus_cyc      = (state == ST_ADDR) || (state == ST_DATA);
  assign bus_io       = bus_cyc && q_io;
  assign bus_wr       = bus_cyc && q_wr;
  assign bus_wide_req = bus_sync && (lane == LN_BOTH);

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_cyc && !rsp_valid))
    else $error("R1 ready during activity");

  a_r3_wide_in_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wide_req |-> (bus_sync && q_be == 2'b11))
    else $error("R3 word request outside a two-byte address phase");

  a_r7_wait_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_sync && bus_wait) |=>
      (bus_cyc && !bus_sync && $stable(bus_addr) && $stable(bus_wdata)))
    else $error("R7 bus changed during wait");

  a_r5_split_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sync && $past(bus_cyc)) |->
      (!bus_wide_req && bus_addr == (($past(bus_addr) + ONE) & (bus_io ? IO_MASK : MEM_MASK))))
    else $error("R5 second byte cycle address wrong");

  a_r9_io_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_io) |-> (bus_addr[MEM_AW-1:IO_AW] == '0))
    else $error("R9 I/O address has upper bits set");

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("R8 response longer than one clock");

endmodule

// File: tb/dyn_width_master_tb.sv
module dyn_width_master_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_io, req_wr;
  logic        req_ready;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_cyc, bus_sync, bus_io, bus_wr, bus_wide_req;
  logic [23:0] bus_addr;
  logic        bus_wide_ack, bus_wait;
  logic [15:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  dyn_width_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_cyc(bus_cyc), .bus_sync(bus_sync), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_wr(bus_wr), .bus_wide_req(bus_wide_req), .bus_wide_ack(bus_wide_ack),
    .bus_wait(bus_wait), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // slave model controls
  logic slave_wide;
  int   slave_wait;
  int   wcnt;
  logic ack_l;
  logic [23:0] lg_addr [8];
  logic        lg_wide [8];
  logic        lg_io   [8];
  logic        lg_wr   [8];
  logic [15:0] lg_wd   [8];
  int          lg_n;

  function automatic logic [7:0] sb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // slave: drives bus inputs at the falling edge
  always @(negedge clk) begin
    logic [23:0] m;
    m = bus_io ? 24'h00FFFF : 24'hFFFFFF;
    if (bus_sync) begin
      ack_l        = slave_wide && bus_wide_req;
      bus_wide_ack = ack_l;
      bus_wait     = 1'b0;
      wcnt         = slave_wait;
      if (lg_n < 8) begin
        lg_addr[lg_n] = bus_addr;
        lg_wide[lg_n] = bus_wide_req;
        lg_io[lg_n]   = bus_io;
        lg_wr[lg_n]   = bus_wr;
      end
      lg_n++;
    end else if (bus_cyc) begin
      bus_wide_ack = 1'b0;
      bus_wait     = (wcnt > 0);
      if (wcnt > 0) wcnt--;
      bus_rdata = ack_l ? {sb((bus_addr + 24'd1) & m), sb(bus_addr)} : {8'hEE, sb(bus_addr)};
      if (lg_n >= 1 && lg_n <= 8) lg_wd[lg_n-1] = bus_wdata;
    end else begin
      bus_wide_ack = 1'b0;
      bus_wait     = 1'b0;
      bus_rdata    = 16'hA5A5;
    end
  end

  task automatic run(input logic [23:0] a, input logic io, input logic wr,
                     input logic [15:0] wd, input logic [1:0] be,
                     input logic wide, input int nw, input logic noise);
    int lat;
    int n;
    logic [23:0] m, a0, a1;
    logic [23:0] e_addr [2];
    logic        e_wide [2];
    logic [15:0] e_wd   [2];
    logic [15:0] e_rd;
    string tag;
    slave_wide = wide;
    slave_wait = nw;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lg_n      = 0;
    req_addr  = a;
    req_io    = io;
    req_wr    = wr;
    req_wdata = wd;
    req_be    = be;
    req_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    if (noise) begin
      req_addr  = ~a;
      req_wdata = ~wd;
      req_be    = ~be;
      req_wr    = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    while (!rsp_valid && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;

    m  = io ? 24'h00FFFF : 24'hFFFFFF;
    a0 = a & m;
    a1 = (a + 24'd1) & m;
    e_rd = 16'h0000;
    n = 0;
    case (be)
      2'b11: begin
        e_rd = {sb(a1), sb(a0)};
        if (wide) begin
          n = 1; e_addr[0] = a0; e_wide[0] = 1'b1; e_wd[0] = wd; tag = "R4";
        end else begin
          n = 2; tag = "R5";
          e_addr[0] = a0; e_wide[0] = 1'b1; e_wd[0] = {8'h00, wd[7:0]};
          e_addr[1] = a1; e_wide[1] = 1'b0; e_wd[1] = {8'h00, wd[15:8]};
        end
      end
      2'b01: begin
        n = 1; tag = "R6"; e_rd = {8'h00, sb(a0)};
        e_addr[0] = a0; e_wide[0] = 1'b0; e_wd[0] = {8'h00, wd[7:0]};
      end
      2'b10: begin
        n = 1; tag = "R6"; e_rd = {sb(a1), 8'h00};
        e_addr[0] = a1; e_wide[0] = 1'b0; e_wd[0] = {8'h00, wd[15:8]};
      end
      default: begin
        n = 0; tag = "R10";
      end
    endcase
    if (wr) e_rd = 16'h0000;

    chk((nw > 0) ? "R7 latency" : "R8 latency", lat, n * (2 + nw) + 1);
    chk({tag, " rdata"}, rsp_rdata, e_rd);
    chk({tag, " cycle count"}, lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk(noise ? "R1 addr" : (io ? "R9 addr" : {tag, " addr"}), lg_addr[i], e_addr[i]);
      chk("R3 wide_req", lg_wide[i], e_wide[i]);
      chk("R9 io", lg_io[i], io);
      chk("R2 wr", lg_wr[i], wr);
      if (wr) chk(noise ? "R1 wdata" : {tag, " wdata"}, lg_wd[i], e_wd[i]);
    end
    @(negedge clk);
    chk("R1 ready after response", req_ready, 1'b1);
    chk("R8 pulse ends", rsp_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; req_valid = 1'b0; req_io = 1'b0; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    bus_wide_ack = 1'b0; bus_wait = 1'b0; bus_rdata = '0;
    slave_wide = 1'b0; slave_wait = 0; lg_n = 0; wcnt = 0; ack_l = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ready", req_ready, 1'b1);
    chk("R11 cyc", bus_cyc, 1'b0);
    chk("R11 wide_req", bus_wide_req, 1'b0);
    chk("R11 rsp", rsp_valid, 1'b0);
    rst_n = 1'b1;

    // directed corners
    run(24'h001230, 1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 0, 1'b0); // R4 wide read
    run(24'h001230, 1'b0, 1'b1, 16'hBEEF, 2'b11, 1'b1, 0, 1'b0); // R4 wide write
    run(24'h004560, 1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 0, 1'b0); // R5 split read
    run(24'h004560, 1'b0, 1'b1, 16'hCAFE, 2'b11, 1'b0, 0, 1'b0); // R5 split write
    run(24'h000777, 1'b0, 1'b0, 16'h0000, 2'b01, 1'b1, 0, 1'b0); // R6 low only
    run(24'h000777, 1'b0, 1'b1, 16'h1234, 2'b10, 1'b1, 0, 1'b0); // R6 high only
    run(24'h000777, 1'b0, 1'b0, 16'h0000, 2'b10, 1'b1, 0, 1'b0); // R6 high read
    run(24'h000100, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b1, 0, 1'b0); // R10
    run(24'hAB_FFFF, 1'b1, 1'b0, 16'h0000, 2'b11, 1'b0, 0, 1'b0); // R9 I/O wrap
    run(24'hFFFFFF, 1'b0, 1'b1, 16'h55AA, 2'b11, 1'b0, 0, 1'b0); // R9 memory wrap
    run(24'h002000, 1'b0, 1'b1, 16'h9876, 2'b11, 1'b0, 3, 1'b0); // R7 waits on split
    run(24'h002002, 1'b1, 1'b0, 16'h0000, 2'b11, 1'b1, 2, 1'b0); // R7 waits on word
    run(24'h003000, 1'b0, 1'b1, 16'h1357, 2'b11, 1'b0, 1, 1'b1); // R1 noise while busy
    run(24'h003100, 1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 0, 1'b1); // R1 noise, byte

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [23:0] ra;
      ra = $urandom();
      run(ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom()),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
          1'($urandom_range(0, 7) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule